// File: doc/BRIEF.md
# Byte Execution Unit with Flag Register

This block is the arithmetic heart of a small 8-bit processor core. It holds a bank of thirty-two byte-wide working registers, an arithmetic/logic unit and an eight-bit flag register. Each clock cycle the surrounding control logic presents a function code together with two register addresses, a left operand and a right operand. The unit computes the result in the same cycle. On the next clock edge it writes that result back into the left-operand register and updates the flags.

Beyond the arithmetic and logic functions, the unit moves single bits between any register and a transfer flag (T), raises and drops an interrupt-enable flag (I), and loads a constant into a register. A separate port overwrites the whole flag register, and the current flag byte is always visible at an output. Both operand registers can be read combinationally through the two read ports, which follow the two address inputs.

The unit is a single-cycle datapath. It has no sequencing states: a new operation can be issued on every cycle, and every operation finishes on the clock edge that follows its issue.

Top module: `exec_core`

## Requirements
- R1: After reset every working register reads 0x00 and the flag byte reads 0x00.
- R2: Function codes: 0 none, 1 add, 2 add with carry, 3 subtract, 4 subtract with borrow, 5 AND, 6 OR, 7 XOR, 8 compare, 9 bit to T, 10 T to bit, 11 interrupt enable, 12 interrupt disable, 13 load constant. Codes 14 and 15 behave like 0.
- R3: Flag byte layout: bit 7 I, bit 6 T, bit 5 H, bit 4 S, bit 3 V, bit 2 N, bit 1 Z, bit 0 C.
- R4: Add and add-with-carry write the sum into the left-operand register one cycle after issue. Add-with-carry also adds the previous C. Operations may be issued on back-to-back cycles.
- R5: Subtract and subtract-with-borrow write left minus right into the left-operand register. Subtract-with-borrow also subtracts the previous C. Compare sets the flags of a plain subtract but leaves every register unchanged.
- R6: For every arithmetic and logic function, Z is 1 exactly when the 8-bit result is zero, and N equals bit 7 of the result.
- R7: For arithmetic functions, C holds the carry (or the borrow) out of bit 7, and H holds the carry (or the borrow) out of bit 3.
- R8: For arithmetic functions, V flags two's-complement overflow. For arithmetic and logic functions, S equals N XOR V.
- R9: AND, OR and XOR write their result to the left operand, clear V, and keep C and H unchanged.
- R10: Function 9 copies bit `bit_sel` of the left-operand register into T and changes no register.
- R11: Function 10 writes T into bit `bit_sel` of the left-operand register. The other seven bits and all flags are unchanged.
- R12: Function 11 sets I and function 12 clears I. Neither changes any other flag or any register.
- R13: A flag-register write loads `sr_wdata` into the flag byte on the next edge. It takes priority over any flag update in the same cycle, while a register write from that cycle still takes place.
- R14: Load-constant writes `imm` into the left-operand register and leaves the flags unchanged. With `op_valid` low, or with code 0, 14 or 15, no register and no flag changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_func | input | 4 | Function code (see R2) |
| lsel | input | 5 | Left operand address, also the destination |
| rsel | input | 5 | Right operand address |
| bit_sel | input | 3 | Bit index for the T transfer functions |
| imm | input | 8 | Constant for load-constant |
| sr_we | input | 1 | Flag register write enable |
| sr_wdata | input | 8 | Flag register write data |
| lval | output | 8 | Current content of register `lsel` |
| rval | output | 8 | Current content of register `rsel` |
| sr_q | output | 8 | Current flag byte |

## Verification
A wrong flag value is visible on `sr_q` one cycle after the operation that produced it. A wrong register value can be seen on `lval` as soon as its address is selected. A flag that was damaged earlier spreads to later results: a bad C changes the next carry-consuming sum, and a bad T changes the next bit inserted by a T-to-bit operation. Each operation is therefore checked in the cycle right after it, starting from flag and register values that were set in advance.

// File: rtl/exec_pkg.sv
package exec_pkg;

    typedef enum logic [3:0] {
        FN_NONE = 4'd0,
        FN_ADD  = 4'd1,
        FN_ADC  = 4'd2,
        FN_SUB  = 4'd3,
        FN_SBC  = 4'd4,
        FN_AND  = 4'd5,
        FN_OR   = 4'd6,
        FN_XOR  = 4'd7,
        FN_CMP  = 4'd8,
        FN_BST  = 4'd9,
        FN_BLD  = 4'd10,
        FN_SEI  = 4'd11,
        FN_CLI  = 4'd12,
        FN_LDC  = 4'd13,
        FN_R14  = 4'd14,
        FN_R15  = 4'd15
    } fn_e;

    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;
    localparam int FL_T = 6;
    localparam int FL_I = 7;

    typedef struct packed {
        logic c;
        logic h;
        logic v;
    } alu_cf_t;

endpackage

// File: rtl/exec_alu.sv
module exec_alu
    import exec_pkg::*;
#(
    parameter int DW = 8
) (
    input  fn_e           fn,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] res,
    output alu_cf_t       cf,
    output logic          is_arith,
    output logic          is_logic
);

    localparam int HB = 4;

    logic          cin_eff;
    logic [DW:0]   sum_w;
    logic [DW:0]   dif_w;
    logic [HB:0]   nsum_w;
    logic [HB:0]   ndif_w;

    always_comb begin
        cin_eff = ((fn == FN_ADC) || (fn == FN_SBC)) ? cin : 1'b0;
        sum_w   = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin_eff};
        dif_w   = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin_eff};
        nsum_w  = {1'b0, a[HB-1:0]} + {1'b0, b[HB-1:0]} + {{HB{1'b0}}, cin_eff};
        ndif_w  = {1'b0, a[HB-1:0]} - {1'b0, b[HB-1:0]} - {{HB{1'b0}}, cin_eff};
    end

    always_comb begin
        res      = '0;
        cf       = '0;
        is_arith = 1'b0;
        is_logic = 1'b0;
        unique case (fn)
            FN_ADD, FN_ADC: begin
                res      = sum_w[DW-1:0];
                cf.c     = sum_w[DW];
                cf.h     = nsum_w[HB];
                cf.v     = (a[DW-1] == b[DW-1]) && (sum_w[DW-1] != a[DW-1]);
                is_arith = 1'b1;
            end
            FN_SUB, FN_SBC, FN_CMP: begin
                res      = dif_w[DW-1:0];
                cf.c     = dif_w[DW];
                cf.h     = ndif_w[HB];
                cf.v     = (a[DW-1] != b[DW-1]) && (dif_w[DW-1] != a[DW-1]);
                is_arith = 1'b1;
            end
            FN_AND: begin
                res      = a & b;
                is_logic = 1'b1;
            end
            FN_OR: begin
                res      = a | b;
                is_logic = 1'b1;
            end
            FN_XOR: begin
                res      = a ^ b;
                is_logic = 1'b1;
            end
            default: begin
                res = '0;
            end
        endcase
    end

endmodule

// File: rtl/exec_regs.sv
module exec_regs #(
    parameter int DW   = 8,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);

    logic [DW-1:0] bank [NREG];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank[gi] <= '0;
            end else if (we && (waddr == AW'(gi))) begin
                bank[gi] <= wdata;
            end
        end
    end

    assign rdata_a = bank[raddr_a];
    assign rdata_b = bank[raddr_b];

endmodule

// File: rtl/exec_sreg.sv
module exec_sreg #(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [FW-1:0] wr_data,
    input  logic [FW-1:0] upd_mask,
    input  logic [FW-1:0] upd_val,
    output logic [FW-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wr_data;
        end else begin
            q <= (q & ~upd_mask) | (upd_val & upd_mask);
        end
    end

    // R13
    sr_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(wr_data)));

    // R14
    sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && (upd_mask == '0)) |=> $stable(q));

endmodule

// File: rtl/exec_core.sv
module exec_core
    import exec_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG),
    localparam int BW  = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_func,
    input  logic [AW-1:0] lsel,
    input  logic [AW-1:0] rsel,
    input  logic [BW-1:0] bit_sel,
    input  logic [DW-1:0] imm,
    input  logic          sr_we,
    input  logic [7:0]    sr_wdata,
    output logic [DW-1:0] lval,
    output logic [DW-1:0] rval,
    output logic [7:0]    sr_q
);

    fn_e           fn;
    logic [DW-1:0] alu_res;
    alu_cf_t       alu_cf;
    logic          alu_arith;
    logic          alu_logic;
    logic          rf_we;
    logic [DW-1:0] rf_wdata;
    logic [7:0]    f_mask;
    logic [7:0]    f_val;
    logic          res_zero;
    logic          res_neg;

    assign fn = op_valid ? fn_e'(op_func) : FN_NONE;

    exec_regs #(.DW(DW), .NREG(NREG)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (lsel),
        .wdata   (rf_wdata),
        .raddr_a (lsel),
        .raddr_b (rsel),
        .rdata_a (lval),
        .rdata_b (rval)
    );

    exec_alu #(.DW(DW)) u_alu (
        .fn       (fn),
        .a        (lval),
        .b        (rval),
        .cin      (sr_q[FL_C]),
        .res      (alu_res),
        .cf       (alu_cf),
        .is_arith (alu_arith),
        .is_logic (alu_logic)
    );

    assign res_zero = (alu_res == '0);
    assign res_neg  = alu_res[DW-1];

    // register write path
    always_comb begin
        rf_we    = 1'b0;
        rf_wdata = alu_res;
        unique case (fn)
            FN_ADD, FN_ADC, FN_SUB, FN_SBC, FN_AND, FN_OR, FN_XOR: begin
                rf_we    = 1'b1;
                rf_wdata = alu_res;
            end
            FN_LDC: begin
                rf_we    = 1'b1;
                rf_wdata = imm;
            end
            FN_BLD: begin
                rf_we             = 1'b1;
                rf_wdata          = lval;
                rf_wdata[bit_sel] = sr_q[FL_T];
            end
            default: begin
                rf_we = 1'b0;
            end
        endcase
    end

    // flag update path
    always_comb begin
        f_mask = '0;
        f_val  = '0;
        if (alu_arith) begin
            f_mask       = 8'b0011_1111;
            f_val[FL_C]  = alu_cf.c;
            f_val[FL_H]  = alu_cf.h;
            f_val[FL_V]  = alu_cf.v;
            f_val[FL_N]  = res_neg;
            f_val[FL_Z]  = res_zero;
            f_val[FL_S]  = res_neg ^ alu_cf.v;
        end else if (alu_logic) begin
            f_mask       = 8'b0001_1110;
            f_val[FL_V]  = 1'b0;
            f_val[FL_N]  = res_neg;
            f_val[FL_Z]  = res_zero;
            f_val[FL_S]  = res_neg;
        end else begin
            unique case (fn)
                FN_BST: begin
                    f_mask[FL_T] = 1'b1;
                    f_val[FL_T]  = lval[bit_sel];
                end
                FN_SEI: begin
                    f_mask[FL_I] = 1'b1;
                    f_val[FL_I]  = 1'b1;
                end
                FN_CLI: begin
                    f_mask[FL_I] = 1'b1;
                    f_val[FL_I]  = 1'b0;
                end
                default: begin
                    f_mask = '0;
                end
            endcase
        end
    end

    exec_sreg #(.FW(8)) u_sreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sr_we),
        .wr_data  (sr_wdata),
        .upd_mask (f_mask),
        .upd_val  (f_val),
        .q        (sr_q)
    );

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((alu_arith || alu_logic) && !sr_we) |=> (sr_q[FL_Z] == ($past(alu_res) == '0)));

    // R6
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((alu_arith || alu_logic) && !sr_we) |=> (sr_q[FL_N] == $past(alu_res[DW-1])));

    // R8
    sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((alu_arith || alu_logic) && !sr_we) |=> (sr_q[FL_S] == (sr_q[FL_N] ^ sr_q[FL_V])));

    // R9
    logic_v_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_logic && !sr_we) |=> (sr_q[FL_V] == 1'b0 && sr_q[FL_C] == $past(sr_q[FL_C])));

    // R12
    int_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == FN_SEI && !sr_we) |=> (sr_q == ($past(sr_q) | 8'h80)));

    // R12
    int_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == FN_CLI && !sr_we) |=> (sr_q == ($past(sr_q) & 8'h7F)));

    // R10
    bit_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == FN_BST && !sr_we) |=> (sr_q[FL_T] == $past(lval[bit_sel])));

    // R2
    fn_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({alu_arith, alu_logic}));

endmodule

// File: tb/exec_core_bench.sv
module exec_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_func = 4'd0;
    logic [4:0] lsel = 5'd0;
    logic [4:0] rsel = 5'd0;
    logic [2:0] bit_sel = 3'd0;
    logic [7:0] imm = 8'd0;
    logic       sr_we = 1'b0;
    logic [7:0] sr_wdata = 8'd0;
    logic [7:0] lval;
    logic [7:0] rval;
    logic [7:0] sr_q;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exec_core u_exec_core (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_func(op_func),
        .lsel(lsel), .rsel(rsel), .bit_sel(bit_sel), .imm(imm),
        .sr_we(sr_we), .sr_wdata(sr_wdata), .lval(lval), .rval(rval), .sr_q(sr_q)
    );

    // {func, a, b, preset flags, expected reg, expected flags}
    localparam logic [43:0] VEC [NVEC] = '{
        {4'd1, 8'h3A, 8'h2C, 8'h00, 8'h66, 8'h20},  // R4 R7 add, half carry
        {4'd1, 8'h7F, 8'h01, 8'h00, 8'h80, 8'h2C},  // R8 add overflow
        {4'd2, 8'hFF, 8'h00, 8'h01, 8'h00, 8'h23},  // R4 R7 adc carry chain
        {4'd3, 8'h10, 8'h01, 8'h00, 8'h0F, 8'h20},  // R5 R7 sub half borrow
        {4'd4, 8'h00, 8'h00, 8'h01, 8'hFF, 8'h35},  // R5 R7 sbc borrow
        {4'd3, 8'h80, 8'h01, 8'h00, 8'h7F, 8'h38},  // R8 sub overflow
        {4'd8, 8'h55, 8'h55, 8'h01, 8'h55, 8'h02},  // R5 compare, no write
        {4'd5, 8'hF0, 8'h3C, 8'h29, 8'h30, 8'h21},  // R9 and, keeps H C
        {4'd6, 8'h80, 8'h01, 8'h00, 8'h81, 8'h14},  // R9 or
        {4'd7, 8'hA5, 8'hA5, 8'h01, 8'h00, 8'h03}   // R6 R9 xor zero
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got=%02h exp=%02h", req, what, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_op(input logic [3:0] f, input logic [4:0] l, input logic [4:0] r,
                          input logic [2:0] b, input logic [7:0] k);
        op_valid = 1'b1; op_func = f; lsel = l; rsel = r; bit_sel = b; imm = k;
        tick();
        op_valid = 1'b0; op_func = 4'd0;
    endtask

    task automatic set_flags(input logic [7:0] v);
        sr_we = 1'b1; sr_wdata = v;
        tick();
        sr_we = 1'b0;
    endtask

    task automatic peek(input logic [4:0] l);
        lsel = l;
        #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [43:0] v;
        repeat (2) @(negedge clk);
        peek(5'd7);
        check("R1", "reset reg", lval, 8'h00);
        check("R1", "reset flags", sr_q, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            run_op(4'd13, 5'd1, 5'd0, 3'd0, v[39:32]);
            run_op(4'd13, 5'd2, 5'd0, 3'd0, v[31:24]);
            set_flags(v[23:16]);
            run_op(v[43:40], 5'd1, 5'd2, 3'd0, 8'h00);
            peek(5'd1);
            check("R4/R5/R9", $sformatf("vector %0d result", i), lval, v[15:8]);
            check("R6/R7/R8", $sformatf("vector %0d flags", i), sr_q, v[7:0]);
        end

        // R4 back-to-back issue: r3=1, r4=2, then r3+=r4 twice in consecutive cycles
        run_op(4'd13, 5'd3, 5'd0, 3'd0, 8'h01);
        run_op(4'd13, 5'd4, 5'd0, 3'd0, 8'h02);
        op_valid = 1'b1; op_func = 4'd1; lsel = 5'd3; rsel = 5'd4;
        tick();
        check("R4", "first of pair", lval, 8'h03);
        tick();
        op_valid = 1'b0; op_func = 4'd0;
        peek(5'd3);
        check("R4", "second of pair", lval, 8'h05);

        // R14 load keeps flags; idle cycle and reserved code change nothing
        set_flags(8'h3F);
        run_op(4'd13, 5'd5, 5'd0, 3'd0, 8'hC3);
        peek(5'd5);
        check("R14", "load value", lval, 8'hC3);
        check("R14", "load flags", sr_q, 8'h3F);
        run_op(4'd14, 5'd5, 5'd5, 3'd0, 8'h00);
        op_func = 4'd1; lsel = 5'd5; rsel = 5'd5;
        tick();
        op_func = 4'd0;
        peek(5'd5);
        check("R14", "reserved/idle reg", lval, 8'hC3);
        check("R14", "reserved/idle flags", sr_q, 8'h3F);

        // R10 bit to T
        set_flags(8'h00);
        run_op(4'd13, 5'd6, 5'd0, 3'd0, 8'h40);
        run_op(4'd9, 5'd6, 5'd0, 3'd6, 8'h00);
        check("R10", "T set", sr_q, 8'h40);
        peek(5'd6);
        check("R10", "source kept", lval, 8'h40);

        // R11 T to bit
        run_op(4'd13, 5'd7, 5'd0, 3'd0, 8'h81);
        run_op(4'd10, 5'd7, 5'd0, 3'd3, 8'h00);
        peek(5'd7);
        check("R11", "bit inserted", lval, 8'h89);
        check("R11", "flags kept", sr_q, 8'h40);
        run_op(4'd9, 5'd6, 5'd0, 3'd0, 8'h00);
        check("R10", "T cleared", sr_q, 8'h00);
        run_op(4'd10, 5'd7, 5'd0, 3'd7, 8'h00);
        peek(5'd7);
        check("R11", "bit cleared", lval, 8'h09);

        // R12 interrupt enable and disable
        set_flags(8'h15);
        run_op(4'd11, 5'd0, 5'd0, 3'd0, 8'h00);
        check("R12", "enable", sr_q, 8'h95);
        run_op(4'd12, 5'd0, 5'd0, 3'd0, 8'h00);
        check("R12", "disable", sr_q, 8'h15);

        // R13 flag write wins over ALU update, register write still occurs
        run_op(4'd13, 5'd8, 5'd0, 3'd0, 8'h00);
        sr_we = 1'b1; sr_wdata = 8'h5A;
        run_op(4'd1, 5'd8, 5'd8, 3'd0, 8'h00);
        sr_we = 1'b0;
        check("R13", "write priority", sr_q, 8'h5A);
        peek(5'd8);
        check("R13", "reg still written", lval, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule